// File: doc/BRIEF.md
# Software-Scheduled Static Crossbar Switch

This block is the switch of one tile in a mesh of tiles. It moves bare payload words between the four neighbouring tiles (north, east, south, west) and the tile's own processor. No word carries a header. Where each word goes is decided ahead of time by a compiled routing program. The program sits in a small instruction memory inside the switch and is loaded through a simple write port.

Each instruction gives every output port a 3-bit source select that names the input feeding it. An instruction completes as a whole or not at all. It retires only when every input it names holds a word and every output it names has room. Until then the program counter holds and no word moves. One input may feed several outputs in the same instruction, and it is consumed once, when all of them take the word. When the instruction at the programmed end address retires, the counter returns to zero, so a fixed routing pattern repeats without any control from outside.

Every link uses a valid/ready handshake and loses no word. A word passes through five register stages: an input buffer, a three-stage transport pipeline and an output buffer. Room in each output is counted with credits, so the transport pipeline never has to stall.

Top module: `static_xbar_switch`

## Requirements
- R1: After reset, every output valid is low, every input ready is high and the program counter is zero.
- R2: Port index order is N=0, E=1, S=2, W=3, local=4. The source select for output o sits in instruction bits [3o+2:3o]. Codes 1 to 5 select input N, E, S, W and local in that order. A routed word appears unchanged on the selected output, and the words on each output keep their input order.
- R3: An instruction retires only when every input it names holds a buffered word and every output it names has room. Otherwise no input is consumed, no word moves and the program counter holds.
- R4: No word is lost or overwritten under back-pressure. Each input buffers 2 words and each output path holds 4 words. With an output blocked, an input routed only to it accepts exactly 6 words and then drops ready. A presented output word stays stable until it is accepted.
- R5: When one input feeds several outputs in one instruction, every one of those outputs receives each word exactly once. If any of them is blocked, none of them receives a new word.
- R6: When the instruction at `end_addr` retires, the program counter returns to zero. Instructions above `end_addr` are never executed.
- R7: With the routing instruction current and the output path empty, a word accepted at clock edge k is presented on its output after edge k+4.
- R8: Source codes 0, 6 and 7 leave that output idle for the instruction, and they place no condition on retiring it.
- R9: While `run` is low, no instruction retires and no word passes through the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Allows instructions to retire |
| prog_we | input | 1 | Instruction memory write strobe |
| prog_addr | input | AW | Instruction memory write address |
| prog_data | input | 15 | Instruction: five 3-bit source selects |
| end_addr | input | AW | Address of the last instruction before wrapping to zero |
| in_data | input | 5x32 | Input words, indexed N, E, S, W, local |
| in_valid | input | 5 | Input word present |
| in_ready | output | 5 | Input buffer can accept a word |
| out_data | output | 5x32 | Output words, indexed N, E, S, W, local |
| out_valid | output | 5 | Output word present |
| out_ready | input | 5 | Receiver accepts the output word |

## Verification
The bench makes an instruction wait on a second source that arrives late. A switch that retired instructions one transfer at a time would let the first word leak out early. It blocks one receiver of a multicast. A switch that consumed the input per output would deliver the word twice or skip words on the blocked port. It fills an output path against a stalled receiver and counts the words accepted. A missing credit check would overflow and drop words, and an early stall would show as a count below six. It also checks the wrap at the end address, the exact five-register latency, the idle codes 6 and 7, and the `run` gate. A wrong wrap would route words through an instruction above the end, and a wrong idle decode would leave an output waiting on a phantom source.

// File: rtl/xbar_pkg.sv
// Shared constants and encodings for the static crossbar switch.
// Assumes five ports in the fixed order N, E, S, W, local.
package xbar_pkg;
    localparam int NPORT = 5;
    localparam int SELW  = 3;
    localparam int IW    = NPORT * SELW;

    localparam int P_N = 0;
    localparam int P_E = 1;
    localparam int P_S = 2;
    localparam int P_W = 3;
    localparam int P_L = 4;

    // Source select codes; the code for input i is i+1, 0 means idle.
    typedef enum logic [SELW-1:0] {
        SRC_NONE  = 3'd0,
        SRC_N     = 3'd1,
        SRC_E     = 3'd2,
        SRC_S     = 3'd3,
        SRC_W     = 3'd4,
        SRC_LOCAL = 3'd5
    } src_sel_e;
endpackage

// File: rtl/sw_fifo.sv
// Small synchronous FIFO used for the input and output buffers of the switch.
// Assumes DEPTH is a power of two and that push is never issued while full.
module sw_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 2,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         not_full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign not_empty = (cnt != '0);
    assign not_full  = (cnt < CW'(DEPTH));
    assign dout      = mem[rp];

    // Storage write: no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (!push && pop) cnt <= cnt - 1'b1;
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < CW'(DEPTH)) || pop);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt != '0);
endmodule

// File: rtl/sw_delay.sv
// Fixed-length transport pipeline between the crossbar and an output buffer.
// Assumes the downstream buffer space was reserved by credit, so it never stalls.
module sw_delay #(
    parameter int W      = 32,
    parameter int STAGES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);
    logic         v [STAGES];
    logic [W-1:0] d [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One pipeline register: valid is reset, data is not.
        always_ff @(posedge clk) begin
            if (!rst_n) v[s] <= 1'b0;
            else        v[s] <= (s == 0) ? in_v : v[(s == 0) ? 0 : s-1];
            d[s] <= (s == 0) ? in_d : d[(s == 0) ? 0 : s-1];
        end
    end

    assign out_v = v[STAGES-1];
    assign out_d = d[STAGES-1];
endmodule

// File: rtl/sw_sched.sv
// Instruction memory, program counter and retire decision of the switch.
// Assumes src_avail and dst_room describe the current cycle only.
module sw_sched
    import xbar_pkg::*;
#(
    parameter int IDEPTH = 16,
    localparam int AW    = $clog2(IDEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       prog_we,
    input  logic [AW-1:0]              prog_addr,
    input  logic [IW-1:0]              prog_data,
    input  logic [AW-1:0]              end_addr,
    input  logic [NPORT-1:0]           src_avail,
    input  logic [NPORT-1:0]           dst_room,
    output logic                       fire,
    output logic [NPORT-1:0]           route_en,
    output logic [NPORT-1:0][SELW-1:0] route_src,
    output logic [NPORT-1:0]           pop
);
    logic [IW-1:0]   imem [IDEPTH];
    logic [AW-1:0]   pc;
    logic [IW-1:0]   instr;
    logic [SELW-1:0] code [NPORT];

    assign instr = imem[pc];

    // Program load port.
    always_ff @(posedge clk) begin
        if (prog_we) imem[prog_addr] <= prog_data;
    end

    // Decode the selects and decide whether the whole instruction can retire.
    always_comb begin
        fire = run;
        pop  = '0;
        for (int o = 0; o < NPORT; o++) begin
            code[o]      = instr[o*SELW +: SELW];
            route_en[o]  = (code[o] != '0) && (int'(code[o]) <= NPORT);
            route_src[o] = route_en[o] ? code[o] - SELW'(1) : '0;
            if (route_en[o] && !(src_avail[route_src[o]] && dst_room[o]))
                fire = 1'b0;
        end
        for (int o = 0; o < NPORT; o++) begin
            if (fire && route_en[o]) pop[route_src[o]] = 1'b1;
        end
    end

    // Program counter: advance on retire, wrap after the end address.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc <= '0;
        else if (fire)  pc <= (pc == end_addr) ? '0 : pc + 1'b1;
    end

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && pc == end_addr) |=> pc == '0);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> pc == $past(pc));
    assert_run_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> pop == '0);
endmodule

// File: rtl/static_xbar_switch.sv
// Static crossbar switch for one tile: input buffers, a program-driven
// crossbar, per-output transport pipelines and credit-tracked output buffers.
// Assumes the program is loaded while run is low, or is being rewritten safely.
module static_xbar_switch
    import xbar_pkg::*;
#(
    parameter int W         = 32,
    parameter int IDEPTH    = 16,
    parameter int IN_DEPTH  = 2,
    parameter int OUT_DEPTH = 4,
    parameter int STAGES    = 5,
    localparam int AW       = $clog2(IDEPTH),
    localparam int PIPE     = STAGES - 2,
    localparam int CRW      = $clog2(OUT_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    prog_we,
    input  logic [AW-1:0]           prog_addr,
    input  logic [IW-1:0]           prog_data,
    input  logic [AW-1:0]           end_addr,
    input  logic [NPORT-1:0][W-1:0] in_data,
    input  logic [NPORT-1:0]        in_valid,
    output logic [NPORT-1:0]        in_ready,
    output logic [NPORT-1:0][W-1:0] out_data,
    output logic [NPORT-1:0]        out_valid,
    input  logic [NPORT-1:0]        out_ready
);
    logic [NPORT-1:0][W-1:0]    head_d;
    logic [NPORT-1:0]           head_v;
    logic [NPORT-1:0]           pop;
    logic [NPORT-1:0]           dst_room;
    logic                       fire;
    logic [NPORT-1:0]           route_en;
    logic [NPORT-1:0][SELW-1:0] route_src;
    logic [NPORT-1:0]           xfer_v;
    logic [NPORT-1:0][W-1:0]    xfer_d;
    logic [NPORT-1:0]           pipe_v;
    logic [NPORT-1:0][W-1:0]    pipe_d;
    logic [NPORT-1:0]           deq;
    logic [CRW-1:0]             credit [NPORT];

    sw_sched #(.IDEPTH(IDEPTH)) u_sched (
        .clk(clk), .rst_n(rst_n), .run(run),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .end_addr(end_addr), .src_avail(head_v), .dst_room(dst_room),
        .fire(fire), .route_en(route_en), .route_src(route_src), .pop(pop)
    );

    // Crossbar: each routed output copies the head word of its selected input.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            xfer_v[o] = fire && route_en[o];
            xfer_d[o] = head_d[route_src[o]];
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic in_nf;

        sw_fifo #(.W(W), .DEPTH(IN_DEPTH)) u_in (
            .clk(clk), .rst_n(rst_n),
            .push(in_valid[p] && in_nf), .din(in_data[p]),
            .pop(pop[p]), .dout(head_d[p]),
            .not_empty(head_v[p]), .not_full(in_nf)
        );
        assign in_ready[p] = in_nf;

        sw_delay #(.W(W), .STAGES(PIPE)) u_pipe (
            .clk(clk), .rst_n(rst_n),
            .in_v(xfer_v[p]), .in_d(xfer_d[p]),
            .out_v(pipe_v[p]), .out_d(pipe_d[p])
        );

        logic out_nf;
        sw_fifo #(.W(W), .DEPTH(OUT_DEPTH)) u_out (
            .clk(clk), .rst_n(rst_n),
            .push(pipe_v[p]), .din(pipe_d[p]),
            .pop(deq[p]), .dout(out_data[p]),
            .not_empty(out_valid[p]), .not_full(out_nf)
        );
        assign deq[p]      = out_valid[p] && out_ready[p];
        assign dst_room[p] = credit[p] < CRW'(OUT_DEPTH);

        // Credit count: words in flight plus words waiting in the output buffer.
        always_ff @(posedge clk) begin
            if (!rst_n)                  credit[p] <= '0;
            else if (xfer_v[p] && !deq[p]) credit[p] <= credit[p] + 1'b1;
            else if (!xfer_v[p] && deq[p]) credit[p] <= credit[p] - 1'b1;
        end

        assert_credit_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
            credit[p] <= CRW'(OUT_DEPTH));
        assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && !out_ready[p]) |=> out_valid[p] && $stable(out_data[p]));
        assert_pop_has_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
            pop[p] |-> head_v[p]);
        assert_room_on_arrival_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pipe_v[p] |-> out_nf || deq[p]);
    end
endmodule

// File: tb/sim_static_xbar_switch.sv
// Scoreboard bench: send tasks push expected words per output, a monitor
// pops and compares each word as the switch delivers it.
module sim_static_xbar_switch;
    import xbar_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int AW = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic run = 0;
    logic prog_we = 0;
    logic [AW-1:0] prog_addr = '0;
    logic [IW-1:0] prog_data = '0;
    logic [AW-1:0] end_addr = '0;
    logic [NPORT-1:0][W-1:0] in_data = '0;
    logic [NPORT-1:0] in_valid = '0;
    logic [NPORT-1:0] in_ready;
    logic [NPORT-1:0][W-1:0] out_data;
    logic [NPORT-1:0] out_valid;
    logic [NPORT-1:0] out_ready = '1;

    int nchk = 0, nfail = 0;
    int cyc = 0;
    int arrivals [NPORT];
    int last_arr [NPORT];
    int acc_cnt [NPORT];
    int acc_cyc;
    bit finished = 0;
    logic [W-1:0] exp_q [NPORT][$];

    static_xbar_switch u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare each delivered word with the head of its expected queue.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int o = 0; o < NPORT; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    arrivals[o]++;
                    last_arr[o] = cyc;
                    if (exp_q[o].size() == 0)
                        chk(0, "R2", $sformatf("unexpected word on out %0d", o), out_data[o], 0);
                    else begin
                        logic [W-1:0] e;
                        e = exp_q[o].pop_front();
                        chk(out_data[o] == e, "R2", $sformatf("word on out %0d", o), out_data[o], e);
                    end
                end
            end
        end
    end

    function automatic logic [IW-1:0] mk(int n, int e, int s, int w, int l);
        return {3'(l), 3'(w), 3'(s), 3'(e), 3'(n)};
    endfunction

    task automatic wr(int a, logic [IW-1:0] v);
        prog_we = 1; prog_addr = AW'(a); prog_data = v;
        @(negedge clk);
        prog_we = 0;
    endtask

    // Reset, clear the program and load a new one; run stays low.
    task automatic restart(logic [IW-1:0] i0, logic [IW-1:0] i1, logic [IW-1:0] i2, int last);
        run = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int a = 0; a < 16; a++) wr(a, '0);
        wr(0, i0); wr(1, i1); wr(2, i2);
        end_addr = AW'(last);
    endtask

    // Driver: present one word on input p and push it to the expected outputs.
    task automatic send(int p, logic [W-1:0] d, logic [NPORT-1:0] dests);
        bit done;
        for (int o = 0; o < NPORT; o++) if (dests[o]) exp_q[o].push_back(d);
        in_data[p] = d; in_valid[p] = 1;
        done = 0;
        while (!done) begin
            done = in_ready[p];
            @(negedge clk);
        end
        in_valid[p] = 0;
        acc_cnt[p]++;
        acc_cyc = cyc;
    endtask

    task automatic stream(int p, logic [W-1:0] base, int n, logic [NPORT-1:0] dests);
        for (int k = 0; k < n; k++) send(p, base + W'(k), dests);
    endtask

    function automatic bit queues_empty();
        for (int o = 0; o < NPORT; o++) if (exp_q[o].size() != 0) return 0;
        return 1;
    endfunction

    initial begin
        for (int o = 0; o < NPORT; o++) begin arrivals[o] = 0; last_arr[o] = 0; acc_cnt[o] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == '1, "R1", "in_ready after reset", in_ready, 31);

        // R2, R6: two-instruction loop with an unused third instruction
        restart(mk(0, 4, 0, 0, 0) | mk(5, 0, 0, 0, 0), mk(0, 0, 1, 2, 0), mk(0, 0, 0, 0, 3), 1);
        run = 1;
        fork
            stream(P_W, 32'h1000, 4, 5'b00010);
            stream(P_L, 32'h2000, 4, 5'b00001);
            stream(P_E, 32'h3000, 4, 5'b01000);
            stream(P_N, 32'h4000, 4, 5'b00100);
        join
        repeat (20) @(negedge clk);
        chk(queues_empty(), "R2", "all routed words delivered", 0, 0);
        chk(arrivals[P_L] == 0, "R6", "instruction above end never ran", arrivals[P_L], 0);

        // R6: wrap alternates N and S; instruction 2 (to E) never runs
        restart(mk(4, 0, 0, 0, 0), mk(0, 0, 4, 0, 0), mk(0, 4, 0, 0, 0), 1);
        for (int o = 0; o < NPORT; o++) arrivals[o] = 0;
        run = 1;
        for (int k = 0; k < 6; k++) send(P_W, 32'h500 + k, (k % 2 == 0) ? 5'b00001 : 5'b00100);
        repeat (15) @(negedge clk);
        chk(arrivals[P_N] == 3 && arrivals[P_S] == 3, "R6", "alternating delivery N count", arrivals[P_N], 3);
        chk(arrivals[P_E] == 0, "R6", "no word on E", arrivals[P_E], 0);

        // R3: instruction needs W and local; only W supplied at first
        restart(mk(4, 0, 5, 0, 0), '0, '0, 0);
        for (int o = 0; o < NPORT; o++) arrivals[o] = 0;
        run = 1;
        send(P_W, 32'hAAA1, 5'b00001);
        repeat (10) @(negedge clk);
        chk(arrivals[P_N] == 0 && out_valid == '0, "R3", "no partial retire", arrivals[P_N], 0);
        send(P_L, 32'hBBB1, 5'b00100);
        repeat (10) @(negedge clk);
        chk(arrivals[P_N] == 1 && arrivals[P_S] == 1, "R3", "both after second source", arrivals[P_N] + arrivals[P_S], 2);

        // R7: exact latency
        restart(mk(0, 0, 0, 2, 0), '0, '0, 0);
        run = 1;
        send(P_E, 32'hC0DE, 5'b01000);
        begin
            int c; c = acc_cyc;
            repeat (10) @(negedge clk);
            chk(last_arr[P_W] == c + 4, "R7", "arrival edge", last_arr[P_W], c + 4);
        end

        // R4: back-pressure capacity and no loss
        restart(mk(2, 0, 0, 0, 0), '0, '0, 0);
        for (int o = 0; o < NPORT; o++) begin arrivals[o] = 0; acc_cnt[o] = 0; end
        out_ready[P_N] = 0;
        run = 1;
        fork
            stream(P_E, 32'h7000, 12, 5'b00001);
        join_none
        repeat (30) @(negedge clk);
        chk(acc_cnt[P_E] == 6, "R4", "words accepted while blocked", acc_cnt[P_E], 6);
        chk(in_ready[P_E] == 0, "R4", "in_ready low when full", in_ready[P_E], 0);
        out_ready[P_N] = 1;
        wait fork;
        repeat (20) @(negedge clk);
        chk(arrivals[P_N] == 12 && queues_empty(), "R4", "all words after release", arrivals[P_N], 12);

        // R5: multicast local to N, E, S with E blocked
        restart(mk(5, 5, 5, 0, 0), '0, '0, 0);
        for (int o = 0; o < NPORT; o++) arrivals[o] = 0;
        out_ready[P_E] = 0;
        run = 1;
        fork
            stream(P_L, 32'h9000, 8, 5'b00111);
        join_none
        repeat (30) @(negedge clk);
        chk(arrivals[P_N] == 4 && arrivals[P_S] == 4, "R5", "others stall with blocked branch", arrivals[P_N], 4);
        out_ready[P_E] = 1;
        wait fork;
        repeat (20) @(negedge clk);
        chk(arrivals[P_N] == 8 && arrivals[P_E] == 8 && arrivals[P_S] == 8, "R5", "each branch got every word", arrivals[P_E], 8);

        // R8: codes 6 and 7 are idle and impose no condition
        restart(mk(6, 4, 7, 0, 0), '0, '0, 0);
        for (int o = 0; o < NPORT; o++) arrivals[o] = 0;
        run = 1;
        send(P_W, 32'hD00D, 5'b00010);
        repeat (10) @(negedge clk);
        chk(arrivals[P_E] == 1, "R8", "word routed past idle codes", arrivals[P_E], 1);
        chk(arrivals[P_N] == 0 && arrivals[P_S] == 0, "R8", "idle outputs silent", arrivals[P_N] + arrivals[P_S], 0);

        // R9: run low blocks everything
        restart(mk(0, 0, 0, 0, 1), '0, '0, 0);
        for (int o = 0; o < NPORT; o++) arrivals[o] = 0;
        send(P_N, 32'hE0E0, 5'b10000);
        repeat (10) @(negedge clk);
        chk(arrivals[P_L] == 0, "R9", "no transfer while run low", arrivals[P_L], 0);
        run = 1;
        repeat (10) @(negedge clk);
        chk(arrivals[P_L] == 1, "R9", "transfer once run high", arrivals[P_L], 1);
        chk(queues_empty(), "R2", "scoreboard drained", 0, 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule